// File: doc/BRIEF.md
# Snoop Control Unit Register Block

This block is the memory-mapped control and status register file of a multiprocessor snoop control unit. It sits behind a simple slave port that carries an 8-bit byte offset, 32-bit write data, an access size given as a byte count, a read strobe, a write strobe and registered read data. The window is 256 bytes.

The block holds three things. The first is a single enable bit. The second is a 32-bit power status word, with one byte per processor. That word can be read or merged at any of its four byte offsets with 1-, 2- or 4-byte accesses. The third is a read-only configuration word, derived from the `NUM_CPU` parameter (range 1 to 4). Every other offset reads as zero and drops writes. This covers the invalidate-all command slot, the filter start and end address slots and the access control slots. A write whose size is not 1, 2 or 4 bytes is discarded.

Top module: `scu_regs`

## Requirements
- R1: A valid write to offset 0x00 stores only data bit 0 in the enable bit. A read of 0x00 returns that bit in bit 0, and bits 31:1 read as zero.
- R2: While rst_ni is low, the enable bit and rdata_o are zero. The power status word is not affected by reset and starts at zero at power-up.
- R3: A read of 0x04 returns ((2^NUM_CPU − 1) << 4) | (NUM_CPU − 1). This gives 0x10 for NUM_CPU=1 and 0xF3 for NUM_CPU=4. Writes to 0x04 are ignored.
- R4: A read of offset 0x08+k (k = 0..3) returns the power status word shifted right by 8·k, with zeros filled in at the top.
- R5: A valid write at offset 0x08+k builds a mask from size_i: 0xFF for 1, 0xFFFF for 2, 0xFFFFFFFF for 4. Both the mask and the data are shifted left by 8·k, and bits moved past bit 31 are dropped. The masked status bits are replaced by the masked data, and all other status bits are kept.
- R6: size_i is a byte count. A write with any size_i value other than 1, 2 or 4 changes no register.
- R7: Offset 0x0C, offsets 0x40, 0x44, 0x50 and 0x54, and every other offset that is not 0x00, 0x04 or 0x08 to 0x0B read as zero, and writes to them change nothing.
- R8: rdata_o is updated on the clock edge that samples rd_i high, and holds its value while rd_i is low. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte offset within the window |
| wdata_i | input | 32 | Write data, right-aligned |
| size_i | input | 3 | Access size in bytes (1, 2, 4 valid) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Registered read data |

## Verification
The bench builds two copies of the block that share their inputs. One copy uses NUM_CPU=4, so every configuration field is filled to its full width (0xF3). The other uses the default NUM_CPU=1 (0x10), so the configuration word is checked at both ends of the parameter range. Because the power status word is always 32 bits, the four-processor copy is enough to cover merges at every byte offset, including 2- and 4-byte writes whose upper bytes fall off the top of the word.

// File: rtl/scu_regs_pkg.sv
package scu_regs_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SIZE_W = 3;
  localparam int LANE_W = $clog2(DATA_W / 8);

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 8'h08;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_CFG,
    SEL_PWR,
    SEL_NONE
  } sel_e;

  function automatic logic size_ok(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      3'd4:    return 32'hffff_ffff;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/scu_decode.sv
module scu_decode
  import scu_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [LANE_W-1:0] lane_o
);

  always_comb begin
    lane_o = addr_i[LANE_W-1:0];
    if (addr_i == OFS_CTRL)                              sel_o = SEL_CTRL;
    else if (addr_i == OFS_CFG)                          sel_o = SEL_CFG;
    else if (addr_i[ADDR_W-1:LANE_W] == OFS_PWR[ADDR_W-1:LANE_W]) sel_o = SEL_PWR;
    else                                                 sel_o = SEL_NONE;
  end

endmodule

// File: rtl/scu_cfg_word.sv
module scu_cfg_word
  import scu_regs_pkg::*;
#(
  parameter int NUM_CPU = 1
) (
  output logic [DATA_W-1:0] cfg_o
);

  localparam int CPU_MASK = (1 << NUM_CPU) - 1;
  localparam logic [DATA_W-1:0] CFG = DATA_W'((CPU_MASK << 4) | (NUM_CPU - 1));

  generate
    if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
      $error("NUM_CPU out of range 1..4");
    end
  endgenerate

  assign cfg_o = CFG;

endmodule

// File: rtl/scu_pwr_status.sv
module scu_pwr_status
  import scu_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] pwr_o
);

  logic [DATA_W-1:0] pwr_q = '0;  // outside reset domain, powers up zero
  logic [DATA_W-1:0] base_mask;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] lane_data;
  logic [4:0]        shamt;

  always_comb begin
    shamt     = {lane_i, 3'b000};
    base_mask = size_mask(size_i);
    lane_mask = base_mask << shamt;              // bits past 31 fall off
    lane_data = (wdata_i & base_mask) << shamt;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) pwr_q <= (pwr_q & ~lane_mask) | lane_data;
  end

  assign pwr_o = pwr_q;

  // R5: bits outside the shifted mask survive a merge
  assert_merge_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (((pwr_q ^ $past(pwr_q)) & ~$past(lane_mask)) == '0));

  // R6: no update without a legal size
  assert_bad_size_pwr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size_ok(size_i) |=> $stable(pwr_q));

endmodule

// File: rtl/scu_regs.sv
module scu_regs
  import scu_regs_pkg::*;
#(
  parameter int NUM_CPU = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [2:0]        size_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [31:0]       rdata_o
);

  sel_e              sel;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] cfg_w;
  logic [DATA_W-1:0] pwr_w;
  logic              wr_ok;
  logic              ctrl_q;

  scu_decode u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .lane_o (lane)
  );

  scu_cfg_word #(.NUM_CPU(NUM_CPU)) u_cfg (
    .cfg_o (cfg_w)
  );

  assign wr_ok = wr_i && size_ok(size_i);

  scu_pwr_status u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_ok && (sel == SEL_PWR)),
    .size_i  (size_i),
    .lane_i  (lane),
    .wdata_i (wdata_i),
    .pwr_o   (pwr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= 1'b0;
    else if (wr_ok && (sel == SEL_CTRL)) ctrl_q <= wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) begin
      case (sel)
        SEL_CTRL: rdata_o <= {{(DATA_W-1){1'b0}}, ctrl_q};
        SEL_CFG:  rdata_o <= cfg_w;
        SEL_PWR:  rdata_o <= pwr_w >> {lane, 3'b000};
        default:  rdata_o <= '0;
      endcase
    end
  end

  assert_ctrl_one_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h00) |=> (rdata_o[31:1] == '0));

  assert_reset_clear_R2: assert property (@(posedge clk_i)
    !rst_ni |-> (!ctrl_q && rdata_o == '0));

  assert_cfg_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h04) |=> (rdata_o == $past(cfg_w)));

  assert_zero_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h0b) |=> (rdata_o[31:8] == '0));

  assert_bad_size_ctrl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !size_ok(size_i)) |=> $stable(ctrl_q));

  assert_hole_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == SEL_NONE) |=> (rdata_o == '0));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/sim_scu_regs.sv
module sim_scu_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  size = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] rdata;
  logic [31:0] rdata1;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  scu_regs #(.NUM_CPU(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .size_i(size), .rd_i(rd), .wr_i(wr), .rdata_o(rdata)
  );

  scu_regs u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .size_i(size), .rd_i(rd), .wr_i(wr), .rdata_o(rdata1)
  );

  // {wr, addr, size, data, expected read, requirement}
  localparam int NV = 47;
  localparam logic [79:0] VEC [NV] = '{
    {1'b0, 8'h08, 3'd4, 32'h0,        32'h0000_0000, 4'd2},  // R2 power-up
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0000_0000, 4'd2},
    {1'b0, 8'h04, 3'd4, 32'h0,        32'h0000_00f3, 4'd3},  // R3
    {1'b1, 8'h04, 3'd4, 32'hffffffff, 32'h0,         4'd3},
    {1'b0, 8'h04, 3'd4, 32'h0,        32'h0000_00f3, 4'd3},
    {1'b1, 8'h08, 3'd4, 32'h11223344, 32'h0,         4'd5},  // R5
    {1'b0, 8'h08, 3'd4, 32'h0,        32'h1122_3344, 4'd5},
    {1'b0, 8'h09, 3'd1, 32'h0,        32'h0011_2233, 4'd4},  // R4
    {1'b0, 8'h0a, 3'd1, 32'h0,        32'h0000_1122, 4'd4},
    {1'b0, 8'h0b, 3'd1, 32'h0,        32'h0000_0011, 4'd4},
    {1'b1, 8'h0a, 3'd1, 32'hffffffab, 32'h0,         4'd5},
    {1'b0, 8'h08, 3'd4, 32'h0,        32'h11ab_3344, 4'd5},
    {1'b1, 8'h09, 3'd2, 32'h0000cdef, 32'h0,         4'd5},
    {1'b0, 8'h08, 3'd4, 32'h0,        32'h11cd_ef44, 4'd5},
    {1'b1, 8'h09, 3'd4, 32'ha1b2c3d4, 32'h0,         4'd5},  // top byte dropped
    {1'b0, 8'h08, 3'd4, 32'h0,        32'hb2c3_d444, 4'd5},
    {1'b1, 8'h0b, 3'd2, 32'h00005566, 32'h0,         4'd5},
    {1'b0, 8'h08, 3'd4, 32'h0,        32'h66c3_d444, 4'd5},
    {1'b0, 8'h0b, 3'd4, 32'h0,        32'h0000_0066, 4'd4},
    {1'b1, 8'h08, 3'd3, 32'h0,        32'h0,         4'd6},  // R6
    {1'b1, 8'h08, 3'd0, 32'h0,        32'h0,         4'd6},
    {1'b1, 8'h08, 3'd7, 32'h0,        32'h0,         4'd6},
    {1'b0, 8'h08, 3'd4, 32'h0,        32'h66c3_d444, 4'd6},
    {1'b1, 8'h00, 3'd3, 32'h1,        32'h0,         4'd6},
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0000_0000, 4'd6},
    {1'b1, 8'h00, 3'd4, 32'hffffffff, 32'h0,         4'd1},  // R1
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0000_0001, 4'd1},
    {1'b1, 8'h00, 3'd1, 32'h000000fe, 32'h0,         4'd1},
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0000_0000, 4'd1},
    {1'b1, 8'h00, 3'd2, 32'h00000003, 32'h0,         4'd1},
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0000_0001, 4'd1},
    {1'b1, 8'h0c, 3'd4, 32'hffffffff, 32'h0,         4'd7},  // R7
    {1'b0, 8'h0c, 3'd4, 32'h0,        32'h0000_0000, 4'd7},
    {1'b1, 8'h40, 3'd4, 32'hffffffff, 32'h0,         4'd7},
    {1'b1, 8'h44, 3'd4, 32'hffffffff, 32'h0,         4'd7},
    {1'b1, 8'h50, 3'd4, 32'hffffffff, 32'h0,         4'd7},
    {1'b1, 8'h54, 3'd4, 32'hffffffff, 32'h0,         4'd7},
    {1'b1, 8'h01, 3'd1, 32'h0,        32'h0,         4'd7},
    {1'b1, 8'hfc, 3'd4, 32'hffffffff, 32'h0,         4'd7},
    {1'b0, 8'h40, 3'd4, 32'h0,        32'h0000_0000, 4'd7},
    {1'b0, 8'h44, 3'd4, 32'h0,        32'h0000_0000, 4'd7},
    {1'b0, 8'h50, 3'd4, 32'h0,        32'h0000_0000, 4'd7},
    {1'b0, 8'h54, 3'd4, 32'h0,        32'h0000_0000, 4'd7},
    {1'b0, 8'h01, 3'd4, 32'h0,        32'h0000_0000, 4'd7},
    {1'b0, 8'hfc, 3'd4, 32'h0,        32'h0000_0000, 4'd7},
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0000_0001, 4'd7},
    {1'b0, 8'h08, 3'd4, 32'h0,        32'h66c3_d444, 4'd7}
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [7:0] a,
                    input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(2, rdata, 32'h0);  // R2 reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      op(v[79], !v[79], v[78:71], v[70:68], v[67:36]);
      if (!v[79]) check(int'(v[3:0]), rdata, v[35:4]);
    end

    // R3: default processor count
    op(1'b0, 1'b1, 8'h04, 3'd4, 32'h0);
    check(3, rdata1, 32'h0000_0010);

    // R8: hold while idle
    op(1'b0, 1'b1, 8'h08, 3'd4, 32'h0);
    repeat (3) begin
      @(negedge clk);
      check(8, rdata, 32'h66c3_d444);
    end
    // R8: read and write together return the old value
    op(1'b1, 1'b1, 8'h08, 3'd4, 32'h0);
    check(8, rdata, 32'h66c3_d444);
    op(1'b0, 1'b1, 8'h08, 3'd4, 32'h0);
    check(8, rdata, 32'h0);

    // R2: reset clears enable and read data, keeps power status
    op(1'b1, 1'b0, 8'h08, 3'd4, 32'hcafe_f00d);
    op(1'b0, 1'b1, 8'h00, 3'd4, 32'h0);
    check(2, rdata, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(2, rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    op(1'b0, 1'b1, 8'h00, 3'd4, 32'h0);
    check(2, rdata, 32'h0);
    op(1'b0, 1'b1, 8'h08, 3'd4, 32'h0);
    check(2, rdata, 32'hcafe_f00d);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule